// File: doc/BRIEF.md
# Variable-Width Serial Master Shift Engine

This block is a serial peripheral master that takes one command word at a time from a transmit queue and clocks it out. Each command word carries its own transfer length of one, two or three bytes, and a left-aligned payload. The payload goes out most significant bit first on the data-out line while the data-in line is sampled. The bits received are then handed to a receive queue as a right-aligned word. A divider sets the serial clock rate. The idle level of the clock is selectable, and so are the edges on which data is launched and sampled.

A per-command hold flag lets a multi-word transaction keep the chip selects asserted across several commands. Every command is followed by a fixed quiet interval on the bus. Both queues connect through plain valid/ready handshakes. The engine holds off popping the next command while the previous received word has not been taken.

Top module: `vw_spi_engine`

## Requirements
- R1: A command word is 32 bits. Bits 28:27 give the byte count: 1 gives 8 bits, 2 gives 16 bits, 3 gives 24 bits, and 0 is treated as 8 bits. Bits 31:29 and 26:24 are ignored. The payload is bits 23:0, and bit 23 is sent first, most significant bit first.
- R2: The received bits are packed so that the last bit received lands in bit 0 of `rx_data`. Bits above the transfer length read as zero.
- R3: Each half period of `sck` lasts `cfg_div + 1` system clocks, so one serial clock period is `2*(cfg_div+1)` system clocks.
- R4: `sck` rests at the level of `cfg_cpol` whenever no command is being shifted. A command of N bits produces exactly 2N transitions of `sck`.
- R5: `mosi` changes only together with an `sck` transition in the direction chosen by `cfg_launch_rise` (1 = rising), apart from presenting the first bit when the command is popped. `miso` is captured on the direction chosen by `cfg_sample_rise`.
- R6: All `cs_n` bits carry the same value, active low. They assert when a command is popped and stay low while `sck` is away from its idle level. For a command without hold, they rise exactly `2*(cfg_div+1)` system clocks after the last `sck` transition.
- R7: A command accepted with `tx_hold` = 1 leaves `cs_n` low into the following command, with no rise in between.
- R8: Between the last `sck` transition of one command and the first transition of the next, at least `4*(cfg_div+1)` system clocks (two serial clock periods) pass.
- R9: `busy` rises on the cycle after a command is popped. It stays high until four half periods after the last `sck` transition. `bits_left` equals the command's bit count right after the pop, drops by one per bit, and is 0 whenever `busy` is low.
- R10: While a received word waits with `rx_ready` low, `tx_ready` is low, no command starts and `sck` stays idle. A pop and the acceptance of the waiting word may happen on the same clock edge.
- R11: Once `rx_valid` is high it stays high with `rx_data` unchanged until `rx_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | 12 | Serial clock divider; half period is cfg_div+1 clocks |
| cfg_cpol | input | 1 | Idle level of sck |
| cfg_launch_rise | input | 1 | 1: launch data on rising sck edge, 0: falling |
| cfg_sample_rise | input | 1 | 1: sample miso on rising sck edge, 0: falling |
| tx_valid | input | 1 | Command word available |
| tx_ready | output | 1 | Engine accepts a command this cycle |
| tx_data | input | 32 | Command word: byte count and payload |
| tx_hold | input | 1 | Keep chip selects asserted after this command |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Receive queue accepts the word |
| rx_data | output | 24 | Right-aligned received bits |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 3 | Chip selects, active low, driven together |
| busy | output | 1 | Command in progress, including trailing quiet time |
| bits_left | output | 6 | Bits still to transfer in the current command |

## Verification
The two functions that can fall on one clock edge are the handover of a waiting received word and the pop of the next command. To provoke this, the bench keeps `rx_ready` low after a command finishes while a second command is already offered. It then raises `rx_ready` in a single cycle. Correct behaviour is judged at the next sample: `busy` must be high and `rx_valid` low. Afterwards both received words must arrive in order with the expected contents, and the looped-back data also shows that no bit was lost or duplicated at the boundary.

// File: rtl/vws_pkg.sv
package vws_pkg;

  localparam int PAY_W  = 24;
  localparam int DIV_W  = 12;
  localparam int CNT_W  = 6;
  localparam int NCS    = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_TAIL
  } vws_state_e;

  // byte-count code to bit count; code 0 falls back to one byte
  function automatic logic [CNT_W-1:0] entry_bits(input logic [1:0] code);
    logic [CNT_W-1:0] n;
    n = '0;
    n[4:3] = code;
    if (code == 2'd0) n = CNT_W'(8);
    return n;
  endfunction

endpackage

// File: rtl/vws_tick.sv
module vws_tick #(
  parameter int DIV_W = vws_pkg::DIV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/vws_shift.sv
module vws_shift #(
  parameter int PAY_W = vws_pkg::PAY_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PAY_W-1:0] payload,
  input  logic             shift_en,
  input  logic             sample_en,
  input  logic             miso,
  output logic             mosi,
  output logic [PAY_W-1:0] rx_word
);

  logic [PAY_W-1:0] tx_sh;
  logic [PAY_W-1:0] rx_sh;

  assign mosi    = tx_sh[PAY_W-1];
  assign rx_word = rx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh <= '0;
      rx_sh <= '0;
    end else if (load) begin
      tx_sh <= payload;
      rx_sh <= '0;
    end else begin
      if (shift_en)  tx_sh <= {tx_sh[PAY_W-2:0], 1'b0};
      if (sample_en) rx_sh <= {rx_sh[PAY_W-2:0], miso};
    end
  end

endmodule

// File: rtl/vws_seq.sv
module vws_seq #(
  parameter int CNT_W = vws_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpol,
  input  logic             launch_rise,
  input  logic             sample_rise,
  input  logic             tick,
  input  logic             pop,
  input  logic [CNT_W-1:0] nbits,
  input  logic             hold,
  output logic             sck,
  output logic             cs_act,
  output logic             busy,
  output logic             idle,
  output logic             shift_en,
  output logic             sample_en,
  output logic             done,
  output logic [CNT_W-1:0] bits_left
);
  import vws_pkg::*;

  vws_state_e       st;
  logic [CNT_W:0]   half_cnt;
  logic [CNT_W:0]   last_half;
  logic [CNT_W-1:0] nbits_r;
  logic             hold_r;
  logic [1:0]       tail_cnt;
  logic             lead_edge;
  logic             launch_lead;
  logic             sample_lead;
  logic             last_hit;
  logic             shifting;

  // a rising edge leads the pulse when the clock idles low
  assign launch_lead = launch_rise ^ cpol;
  assign sample_lead = sample_rise ^ cpol;
  assign lead_edge   = ~half_cnt[0];
  assign last_half   = {nbits_r, 1'b0} - 1'b1;
  assign last_hit    = (half_cnt == last_half);
  assign shifting    = (st == ST_SHIFT) && tick;

  // first bit is preloaded; the trailing edge of the last bit launches nothing
  assign shift_en  = shifting && (lead_edge == launch_lead)
                   && !(lead_edge && (half_cnt == '0))
                   && !(!lead_edge && last_hit);
  assign sample_en = shifting && (lead_edge == sample_lead);

  assign busy = (st != ST_IDLE);
  assign idle = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      sck       <= cpol;
      cs_act    <= 1'b0;
      half_cnt  <= '0;
      nbits_r   <= '0;
      hold_r    <= 1'b0;
      tail_cnt  <= '0;
      bits_left <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          sck <= cpol;
          if (pop) begin
            st        <= ST_SETUP;
            cs_act    <= 1'b1;
            nbits_r   <= nbits;
            bits_left <= nbits;
            hold_r    <= hold;
            half_cnt  <= '0;
          end
        end
        ST_SETUP: begin
          if (tick) st <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (tick) begin
            sck <= ~sck;
            if (!lead_edge) bits_left <= bits_left - 1'b1;
            if (last_hit) begin
              st       <= ST_TAIL;
              tail_cnt <= '0;
              done     <= 1'b1;
            end else begin
              half_cnt <= half_cnt + 1'b1;
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            tail_cnt <= tail_cnt + 1'b1;
            if (tail_cnt == 2'd1 && !hold_r) cs_act <= 1'b0;
            if (tail_cnt == 2'd3) st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vw_spi_engine.sv
module vw_spi_engine #(
  parameter int DIV_W = vws_pkg::DIV_W,
  parameter int PAY_W = vws_pkg::PAY_W,
  parameter int CNT_W = vws_pkg::CNT_W,
  parameter int NCS   = vws_pkg::NCS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_cpol,
  input  logic             cfg_launch_rise,
  input  logic             cfg_sample_rise,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [PAY_W+7:0] tx_data,
  input  logic             tx_hold,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [PAY_W-1:0] rx_data,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  output logic [NCS-1:0]   cs_n,
  output logic             busy,
  output logic [CNT_W-1:0] bits_left
);
  import vws_pkg::*;

  localparam int CODE_LO = PAY_W + 3;

  logic             tick;
  logic             idle;
  logic             pop;
  logic             cs_act;
  logic             shift_en;
  logic             sample_en;
  logic             done;
  logic [CNT_W-1:0] nbits;
  logic [PAY_W-1:0] rx_word;
  logic             unused_fields;

  assign unused_fields = ^{tx_data[PAY_W+7:CODE_LO+2], tx_data[CODE_LO-1:PAY_W]};

  assign nbits    = entry_bits(tx_data[CODE_LO+1:CODE_LO]);
  assign tx_ready = idle && (!rx_valid || rx_ready);
  assign pop      = tx_valid && tx_ready;

  vws_tick #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .div  (cfg_div),
    .tick (tick)
  );

  vws_seq #(.CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .cpol        (cfg_cpol),
    .launch_rise (cfg_launch_rise),
    .sample_rise (cfg_sample_rise),
    .tick        (tick),
    .pop         (pop),
    .nbits       (nbits),
    .hold        (tx_hold),
    .sck         (sck),
    .cs_act      (cs_act),
    .busy        (busy),
    .idle        (idle),
    .shift_en    (shift_en),
    .sample_en   (sample_en),
    .done        (done),
    .bits_left   (bits_left)
  );

  vws_shift #(.PAY_W(PAY_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (pop),
    .payload   (tx_data[PAY_W-1:0]),
    .shift_en  (shift_en),
    .sample_en (sample_en),
    .miso      (miso),
    .mosi      (mosi),
    .rx_word   (rx_word)
  );

  // single receive slot; a new command is only popped once it is free
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else if (done) begin
      rx_valid <= 1'b1;
      rx_data  <= rx_word;
    end else if (rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    assign cs_n[g] = ~cs_act;
  end

endmodule

// File: rtl/vws_chk.sv
module vws_chk #(
  parameter int DIV_W = vws_pkg::DIV_W,
  parameter int PAY_W = vws_pkg::PAY_W,
  parameter int CNT_W = vws_pkg::CNT_W,
  parameter int NCS   = vws_pkg::NCS
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_cpol,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic [PAY_W-1:0] rx_data,
  input logic             sck,
  input logic [NCS-1:0]   cs_n,
  input logic             busy,
  input logic [CNT_W-1:0] bits_left
);

  // R6
  cs_group_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_n == '0) || (cs_n == '1));

  // R6
  cs_active_chk: assert property (@(posedge clk) disable iff (rst)
    (sck != cfg_cpol) && $stable(cfg_cpol) |-> cs_n == '0);

  // R4
  sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy && $stable(cfg_cpol) |-> sck == cfg_cpol);

  // R9
  pop_busy_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid && tx_ready |=> busy && (bits_left != '0));

  // R9
  idle_count_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> bits_left == '0);

  // R11
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));

  // R10
  stall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid && !rx_ready && $stable(cfg_cpol) |=> $stable(sck));

endmodule

bind vw_spi_engine vws_chk #(
  .DIV_W(DIV_W), .PAY_W(PAY_W), .CNT_W(CNT_W), .NCS(NCS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_cpol  (cfg_cpol),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .rx_data   (rx_data),
  .sck       (sck),
  .cs_n      (cs_n),
  .busy      (busy),
  .bits_left (bits_left)
);

// File: tb/sim_vw_spi_engine.sv
`timescale 1ns/1ps
module sim_vw_spi_engine;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] cfg_div = '0;
  logic        cfg_cpol = 1'b0;
  logic        cfg_launch_rise = 1'b0;
  logic        cfg_sample_rise = 1'b1;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [31:0] tx_data = '0;
  logic        tx_hold = 1'b0;
  logic        rx_valid;
  logic        rx_ready = 1'b1;
  logic [23:0] rx_data;
  logic        sck;
  logic        mosi;
  logic        miso;
  logic [2:0]  cs_n;
  logic        busy;
  logic [5:0]  bits_left;

  always #2.5 clk = ~clk;

  assign miso = mosi;  // loopback

  vw_spi_engine u0 (
    .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_cpol(cfg_cpol),
    .cfg_launch_rise(cfg_launch_rise), .cfg_sample_rise(cfg_sample_rise),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_hold(tx_hold),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n), .busy(busy),
    .bits_left(bits_left)
  );

  typedef struct packed {
    logic        cpol;
    logic        lr;
    logic        sr;
    logic [11:0] div;
    logic [31:0] word;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b0, 1'b1, 12'd0, 32'h08A50000},
    '{1'b0, 1'b1, 1'b0, 12'd1, 32'h10C35A00},
    '{1'b1, 1'b1, 1'b0, 12'd2, 32'h18123456},
    '{1'b1, 1'b0, 1'b1, 12'd3, 32'h18F0E1D2},
    '{1'b0, 1'b0, 1'b1, 12'd0, 32'h007E0000},
    '{1'b0, 1'b1, 1'b0, 12'd4, 32'hE8010000}
  };

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor state
  int   edges, min_gap, max_gap, last_tr, cs_rises, cs_delta, viol, rx_cnt;
  bit   have_tr;
  logic cur_lr;
  logic p_sck = 1'b0, p_mosi = 1'b0, p_busy = 1'b0, p_rxv = 1'b0;
  logic [2:0]  p_cs = 3'b111;
  logic [23:0] rx_log [32];

  initial begin
    edges = 0; min_gap = 1000000; max_gap = 0; last_tr = 0;
    cs_rises = 0; cs_delta = -1; viol = 0; rx_cnt = 0; have_tr = 1'b0; cur_lr = 1'b0;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (sck !== p_sck) begin
        edges++;
        if (have_tr) begin
          if (cyc - last_tr < min_gap) min_gap = cyc - last_tr;
          if (cyc - last_tr > max_gap) max_gap = cyc - last_tr;
        end
        have_tr = 1'b1;
        last_tr = cyc;
      end
      if (p_busy && busy && (mosi !== p_mosi))
        if (!((sck !== p_sck) && ((sck == 1'b1) == cur_lr))) viol++;
      if (p_cs == 3'b000 && cs_n == 3'b111) begin
        cs_rises++;
        cs_delta = cyc - last_tr;
      end
      if (rx_valid && !p_rxv) begin
        rx_log[rx_cnt[4:0]] = rx_data;
        rx_cnt++;
      end
    end
    p_sck = sck; p_mosi = mosi; p_busy = busy; p_rxv = rx_valid; p_cs = cs_n;
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic clear_stats();
    edges = 0; min_gap = 1000000; max_gap = 0; have_tr = 1'b0;
    cs_rises = 0; cs_delta = -1; viol = 0;
  endtask

  task automatic apply_cfg(input logic cp, input logic lr, input logic sr, input logic [11:0] dv);
    @(negedge clk);
    cfg_cpol = cp; cfg_launch_rise = lr; cfg_sample_rise = sr; cfg_div = dv;
    cur_lr = lr;
    repeat (3) @(negedge clk);
    clear_stats();
  endtask

  task automatic push_tx(input logic [31:0] w, input logic h);
    tx_data = w; tx_hold = h; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_done(input int target);
    while (!(busy == 1'b0 && cs_n == 3'b111 && rx_cnt >= target)) @(negedge clk);
  endtask

  function automatic int exp_bits(input logic [31:0] w);
    return (w[28:27] == 2'd0) ? 8 : 8 * int'(w[28:27]);
  endfunction

  function automatic int exp_rx(input logic [31:0] w);
    return int'(w[23:0] >> (24 - exp_bits(w)));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual=%0d expected=finished", cyc);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int start;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state (R4, R9, R6, R10, R11)
    chk("R6", "cs_n after reset", int'(cs_n), 7);
    chk("R9", "busy after reset", int'(busy), 0);
    chk("R9", "bits_left after reset", int'(bits_left), 0);
    chk("R11", "rx_valid after reset", int'(rx_valid), 0);
    chk("R10", "tx_ready after reset", int'(tx_ready), 1);
    chk("R4", "sck idle after reset", int'(sck), 0);

    // vector walk: R1 R2 R3 R4 R5 R6 R9
    for (int v = 0; v < 6; v++) begin
      apply_cfg(VECS[v].cpol, VECS[v].lr, VECS[v].sr, VECS[v].div);
      rx_ready = 1'b1;
      start = rx_cnt;
      push_tx(VECS[v].word, 1'b0);
      chk("R9", "busy after pop", int'(busy), 1);
      chk("R9", "bits_left after pop", int'(bits_left), exp_bits(VECS[v].word));
      wait_done(start + 1);
      chk("R1 R2 R5", "loopback word", int'(rx_log[start[4:0]]), exp_rx(VECS[v].word));
      chk("R4", "sck transitions", edges, 2 * exp_bits(VECS[v].word));
      chk("R3", "half period", min_gap, int'(VECS[v].div) + 1);
      chk("R6", "cs release delay", cs_delta, 2 * (int'(VECS[v].div) + 1));
      chk("R4", "sck idle level", int'(sck), int'(VECS[v].cpol));
      chk("R5", "mosi off launch edge", viol, 0);
      chk("R9", "bits_left when idle", int'(bits_left), 0);
    end

    // hold between two commands: R7 R8
    apply_cfg(1'b0, 1'b1, 1'b0, 12'd1);
    rx_ready = 1'b1;
    start = rx_cnt;
    push_tx(32'h083C0000, 1'b1);
    push_tx(32'h08990000, 1'b0);
    wait_done(start + 2);
    chk("R7", "cs rises across held pair", cs_rises, 1);
    chk("R8", "gap at least two periods", int'(max_gap >= 8), 1);
    chk("R7", "first held word", int'(rx_log[start[4:0]]), 'h3C);
    chk("R7", "second word", int'(rx_log[(start + 1) % 32]), 'h99);
    chk("R4", "transitions for pair", edges, 32);

    // receive stall and same-edge handover: R10 R11
    apply_cfg(1'b0, 1'b0, 1'b1, 12'd1);
    rx_ready = 1'b0;
    start = rx_cnt;
    push_tx(32'h08550000, 1'b0);
    tx_data = 32'h08AA0000; tx_hold = 1'b0; tx_valid = 1'b1;
    while (!(rx_valid && !busy)) @(negedge clk);
    repeat (60) @(negedge clk);
    chk("R10", "no second command while stalled", edges, 16);
    chk("R10", "tx_ready low while stalled", int'(tx_ready), 0);
    chk("R10", "sck idle while stalled", int'(sck), 0);
    chk("R11", "rx_valid held", int'(rx_valid), 1);
    chk("R11", "rx_data held", int'(rx_data), 'h55);
    rx_ready = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    chk("R10", "pop on drain edge", int'(busy), 1);
    chk("R10", "word drained on same edge", int'(rx_valid), 0);
    wait_done(start + 2);
    chk("R10", "first word after stall", int'(rx_log[start[4:0]]), 'h55);
    chk("R10", "second word after stall", int'(rx_log[(start + 1) % 32]), 'hAA);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule